// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block walks a multi-register memory transfer one register at a time. A command carries a base address, a 16-bit mask that selects the registers taking part, and four control bits: counting direction, pre- or post-stepping, load or store, and write-back. For each selected register the block presents one bus request. The request gives the word address, the register index, the access direction and a tag that tells the memory whether the access follows on from the one before it.

Each request is held until the consumer takes it with a valid/ready handshake, so a slow memory stalls the walk without losing any state. After the last transfer the block produces a single completion pulse. The pulse carries the corrected base value for write-back, a flag saying whether write-back applies, and a flush request when a load has replaced the program counter register (index 15). A load walk spends one internal cycle between its last transfer and the completion pulse. The data path, the register file and mode banking sit outside the block.

Top module: `blk_xfer_seq`

## Requirements
- R1: A command is taken only when `cmd_start` is high while `busy` is low. `busy` rises in the cycle after acceptance and stays high until completion. `cmd_start` has no effect while `busy` is high.
- R2: Consecutive addresses differ by 4 bytes: increasing when `cmd_up`=1, decreasing when `cmd_up`=0. The first address is the base when `cmd_pre`=0, and the base stepped once in the counting direction when `cmd_pre`=1.
- R3: With `cmd_up`=1 the selected registers are requested in ascending index order (mask bit i is register i). With `cmd_up`=0 they are requested in descending order.
- R4: The first request of every command has `req_seq`=0 (non-sequential). Every later request of the same command has `req_seq`=1. `req_write` is 1 for a store (`cmd_load`=0) and 0 for a load.
- R5: A request advances only on a cycle where `req_valid` and `req_ready` are both high. While `req_ready` is low, `req_addr`, `req_reg` and `req_seq` are held.
- R6: At completion, `wb_addr` equals the base plus 4·n when counting up, or the base minus 4·n when counting down, where n is the number of selected registers. This holds for both indexing modes and wraps modulo 2^32. `wb_valid` is 1 exactly when `cmd_pre`=0 or `cmd_wb`=1.
- R7: `flush_req` is high during the completion pulse exactly when the command was a load and mask bit 15 was set. At all other times it is low.
- R8: For a load, `int_cycle` is high for exactly one cycle, in the cycle after the final handshake, and `done` follows in the next cycle. A store never raises `int_cycle`.
- R9: An all-zero mask produces no request. `done` is then high in the cycle after acceptance, with write-back values equal to the base.
- R10: `done` is high for exactly one cycle per command, and `busy` is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Request to begin a command |
| cmd_base | input | 32 | Base address |
| cmd_mask | input | 16 | Register-select mask, bit i selects register i |
| cmd_up | input | 1 | 1 = addresses increase, 0 = decrease |
| cmd_pre | input | 1 | 1 = step before each transfer, 0 = after |
| cmd_load | input | 1 | 1 = load, 0 = store |
| cmd_wb | input | 1 | Write-back requested |
| busy | output | 1 | Command in progress |
| req_valid | output | 1 | Bus request present |
| req_ready | input | 1 | Consumer takes the request |
| req_addr | output | 32 | Word address of the request |
| req_reg | output | 4 | Register index of the request |
| req_write | output | 1 | 1 = store access |
| req_seq | output | 1 | 1 = sequential, 0 = non-sequential |
| int_cycle | output | 1 | Internal cycle that ends a load |
| done | output | 1 | One-cycle completion pulse |
| wb_valid | output | 1 | Base register update applies (with done) |
| wb_addr | output | 32 | Value for base write-back (with done) |
| flush_req | output | 1 | Program counter was loaded (with done) |

## Verification
- **First request:** a request is visible in the cycle after the accepting edge.
- **Advancing:** each handshake edge moves to the next request, or ends the walk.
- **Completion:** after the final handshake, `done` arrives one cycle later for a store and two cycles later for a load, with the internal cycle in between. An empty mask gives `done` one cycle after acceptance.
- **Checking:** the bench drives inputs and samples outputs on falling edges. It tracks the expected address, index and tag per handshake from its own model, and checks completion outputs exactly at the cycle these latencies predict, so an early or late pulse is reported.

// File: rtl/bts_pkg.sv
// Package: shared state encoding for the block transfer sequencer.
// Assumes: nothing beyond being compiled first.
package bts_pkg;

    // Sequencer phases: idle, issuing requests, load settle cycle, completion pulse
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_ISSUE  = 2'd1,
        SQ_SETTLE = 2'd2,
        SQ_FINISH = 2'd3
    } seq_state_e;

endpackage

// File: rtl/bts_pick.sv
// Module: bts_pick
// Picks the next register to transfer from a pending mask: the lowest set
// bit when counting up, the highest set bit when counting down. Also gives
// the one-hot of the pick so the caller can retire it.
// Assumes: NREG >= 2; purely combinational.
module bts_pick #(
    parameter int NREG = 16,
    localparam int IW = $clog2(NREG)
) (
    input  logic [NREG-1:0] pend,
    input  logic            up,
    output logic            any,
    output logic [IW-1:0]   idx,
    output logic [NREG-1:0] onehot
);

    logic [IW-1:0] lo_idx;
    logic [IW-1:0] hi_idx;

    // Lowest set bit: scan downward so the last hit wins
    always_comb begin
        lo_idx = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (pend[i]) lo_idx = IW'(i);
        end
    end

    // Highest set bit: scan upward so the last hit wins
    always_comb begin
        hi_idx = '0;
        for (int i = 0; i < NREG; i++) begin
            if (pend[i]) hi_idx = IW'(i);
        end
    end

    // Direction picks the scan result; any pending bit means a pick exists
    always_comb begin
        any = |pend;
        idx = up ? lo_idx : hi_idx;
    end

    // One-hot of the chosen index, one decoder per register
    for (genvar g = 0; g < NREG; g++) begin : g_oh
        assign onehot[g] = any && (idx == IW'(g));
    end

endmodule

// File: rtl/bts_addr.sv
// Module: bts_addr
// Address register of the sequencer. Loaded at command acceptance with the
// base, pre-stepped when pre-indexing; stepped once per accepted transfer.
// Derives the write-back value by undoing the pre-step.
// Assumes: ld and adv never high together; step direction held by caller.
module bts_addr #(
    parameter int AW   = 32,
    parameter int STEP = 4,
    localparam logic [AW-1:0] STEP_V = AW'(STEP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [AW-1:0] base,
    input  logic          ld_up,
    input  logic          ld_pre,
    input  logic          adv,
    input  logic          up_q,
    input  logic          pre_q,
    output logic [AW-1:0] cur,
    output logic [AW-1:0] wb_val
);

    logic [AW-1:0] base_init;
    logic [AW-1:0] cur_next;

    // Starting address: base, or base moved one step when pre-indexing
    always_comb begin
        if (ld_pre) base_init = ld_up ? base + STEP_V : base - STEP_V;
        else        base_init = base;
    end

    // Running address after one accepted transfer
    always_comb begin
        cur_next = up_q ? cur + STEP_V : cur - STEP_V;
    end

    // Address register: load on accept, step on handshake
    always_ff @(posedge clk) begin
        if (!rst_n)   cur <= '0;
        else if (ld)  cur <= base_init;
        else if (adv) cur <= cur_next;
    end

    // Write-back value: remove the extra pre-step after the last transfer
    always_comb begin
        if (pre_q) wb_val = up_q ? cur - STEP_V : cur + STEP_V;
        else       wb_val = cur;
    end

endmodule

// File: rtl/bts_ctrl.sv
// Module: bts_ctrl
// Control of the sequencer: accepts a command, latches its flags, walks
// the pending mask through the picker, tags accesses, inserts the settle
// cycle after loads and raises the completion pulse.
// Assumes: req_ready may change freely; command inputs sampled at accept.
module bts_ctrl
    import bts_pkg::*;
#(
    parameter int NREG = 16,
    localparam int IW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [NREG-1:0] mask,
    input  logic            up,
    input  logic            pre,
    input  logic            load,
    input  logic            wb,
    input  logic            ready,
    output logic            accept,
    output logic            adv,
    output logic            up_q,
    output logic            pre_q,
    output logic            busy,
    output logic            valid,
    output logic [IW-1:0]   reg_idx,
    output logic            write,
    output logic            seq,
    output logic            settle,
    output logic            done,
    output logic            wb_ok,
    output logic            flush
);

    seq_state_e      state;
    seq_state_e      state_nx;
    logic [NREG-1:0] pend;
    logic [NREG-1:0] pend_left;
    logic [NREG-1:0] pick_oh;
    logic            pick_any;
    logic            first_q;
    logic            load_q;
    logic            wb_q;
    logic            flush_q;

    bts_pick #(.NREG(NREG)) u_pick (
        .pend   (pend),
        .up     (up_q),
        .any    (pick_any),
        .idx    (reg_idx),
        .onehot (pick_oh)
    );

    // Handshake and acceptance qualifiers
    always_comb begin
        accept    = start && (state == SQ_IDLE);
        adv       = valid && ready;
        pend_left = pend & ~pick_oh;
    end

    // Next phase of the walk
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE:   if (accept) state_nx = (|mask) ? SQ_ISSUE : SQ_FINISH;
            SQ_ISSUE:  if (adv && !(|pend_left))
                           state_nx = load_q ? SQ_SETTLE : SQ_FINISH;
            SQ_SETTLE: state_nx = SQ_FINISH;
            SQ_FINISH: state_nx = SQ_IDLE;
            default:   state_nx = SQ_IDLE;
        endcase
    end

    // Phase register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nx;
    end

    // Pending mask: loaded at accept, one bit retired per handshake
    always_ff @(posedge clk) begin
        if (!rst_n)      pend <= '0;
        else if (accept) pend <= mask;
        else if (adv)    pend <= pend_left;
    end

    // First-access marker: set at accept, cleared by the first handshake
    always_ff @(posedge clk) begin
        if (!rst_n)      first_q <= 1'b0;
        else if (accept) first_q <= 1'b1;
        else if (adv)    first_q <= 1'b0;
    end

    // Command flags held for the whole walk
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_q    <= 1'b0;
            pre_q   <= 1'b0;
            load_q  <= 1'b0;
            wb_q    <= 1'b0;
            flush_q <= 1'b0;
        end else if (accept) begin
            up_q    <= up;
            pre_q   <= pre;
            load_q  <= load;
            wb_q    <= wb;
            flush_q <= load && mask[NREG-1];
        end
    end

    // Outputs decoded from the phase and held flags
    always_comb begin
        busy   = (state != SQ_IDLE);
        valid  = (state == SQ_ISSUE) && pick_any;
        write  = !load_q;
        seq    = !first_q;
        settle = (state == SQ_SETTLE);
        done   = (state == SQ_FINISH);
        wb_ok  = done && (!pre_q || wb_q);
        flush  = done && flush_q;
    end

endmodule

// File: rtl/blk_xfer_seq.sv
// Module: blk_xfer_seq (top)
// Sequences a multi-register load/store into one handshaked bus request
// per selected register, then reports write-back value and flush need.
// Assumes: one command at a time; requests consumed through req_ready.
module blk_xfer_seq #(
    parameter int AW   = 32,
    parameter int NREG = 16,
    parameter int STEP = 4,
    localparam int IW = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_start,
    input  logic [AW-1:0]   cmd_base,
    input  logic [NREG-1:0] cmd_mask,
    input  logic            cmd_up,
    input  logic            cmd_pre,
    input  logic            cmd_load,
    input  logic            cmd_wb,
    output logic            busy,
    output logic            req_valid,
    input  logic            req_ready,
    output logic [AW-1:0]   req_addr,
    output logic [IW-1:0]   req_reg,
    output logic            req_write,
    output logic            req_seq,
    output logic            int_cycle,
    output logic            done,
    output logic            wb_valid,
    output logic [AW-1:0]   wb_addr,
    output logic            flush_req
);

    logic accept;
    logic adv;
    logic dir_up_q;
    logic pre_q;

    bts_ctrl #(.NREG(NREG)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (cmd_start),
        .mask    (cmd_mask),
        .up      (cmd_up),
        .pre     (cmd_pre),
        .load    (cmd_load),
        .wb      (cmd_wb),
        .ready   (req_ready),
        .accept  (accept),
        .adv     (adv),
        .up_q    (dir_up_q),
        .pre_q   (pre_q),
        .busy    (busy),
        .valid   (req_valid),
        .reg_idx (req_reg),
        .write   (req_write),
        .seq     (req_seq),
        .settle  (int_cycle),
        .done    (done),
        .wb_ok   (wb_valid),
        .flush   (flush_req)
    );

    bts_addr #(.AW(AW), .STEP(STEP)) u_addr (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (accept),
        .base   (cmd_base),
        .ld_up  (cmd_up),
        .ld_pre (cmd_pre),
        .adv    (adv),
        .up_q   (dir_up_q),
        .pre_q  (pre_q),
        .cur    (req_addr),
        .wb_val (wb_addr)
    );

endmodule

// File: rtl/bts_chk.sv
// Module: bts_chk
// Temporal checks on the sequencer, bound into every blk_xfer_seq.
// Assumes: dir_up is the held direction of the current command.
module bts_chk #(
    parameter int AW = 32,
    parameter int IW = 4,
    localparam logic [AW-1:0] STEP_V = AW'(4)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic [IW-1:0] req_reg,
    input logic          req_seq,
    input logic          int_cycle,
    input logic          done,
    input logic          flush_req,
    input logic          dir_up
);

    // R1
    valid_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> busy);

    // R5
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
            (req_valid && $stable(req_addr) && $stable(req_reg) && $stable(req_seq)));

    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=>
            (!req_valid || req_addr == (dir_up ? $past(req_addr) + STEP_V
                                               : $past(req_addr) - STEP_V)));

    // R4
    seq_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!req_valid || req_seq));

    // R8
    settle_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int_cycle |=> (done && !int_cycle));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R7
    flush_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_req |-> done);

endmodule

bind blk_xfer_seq bts_chk #(.AW(AW), .IW(IW)) u_bts_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .req_reg   (req_reg),
    .req_seq   (req_seq),
    .int_cycle (int_cycle),
    .done      (done),
    .flush_req (flush_req),
    .dir_up    (dir_up_q)
);

// File: tb/sim_blk_xfer_seq.sv
module sim_blk_xfer_seq;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [31:0] cmd_base = '0;
    logic [15:0] cmd_mask = '0;
    logic        cmd_up = 1'b0;
    logic        cmd_pre = 1'b0;
    logic        cmd_load = 1'b0;
    logic        cmd_wb = 1'b0;
    logic        busy;
    logic        req_valid;
    logic        req_ready = 1'b0;
    logic [31:0] req_addr;
    logic [3:0]  req_reg;
    logic        req_write;
    logic        req_seq;
    logic        int_cycle;
    logic        done;
    logic        wb_valid;
    logic [31:0] wb_addr;
    logic        flush_req;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    blk_xfer_seq u0 (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_base(cmd_base),
        .cmd_mask(cmd_mask), .cmd_up(cmd_up), .cmd_pre(cmd_pre),
        .cmd_load(cmd_load), .cmd_wb(cmd_wb), .busy(busy),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_reg(req_reg), .req_write(req_write), .req_seq(req_seq),
        .int_cycle(int_cycle), .done(done), .wb_valid(wb_valid),
        .wb_addr(wb_addr), .flush_req(flush_req)
    );

    // {base[32], mask[16], up, pre, load, wb, ready pattern[8]}
    localparam logic [59:0] VEC [0:7] = '{
        {32'h0000_1000, 16'h00F1, 1'b1, 1'b0, 1'b0, 1'b0, 8'hFF},
        {32'h0000_2000, 16'h8003, 1'b1, 1'b1, 1'b1, 1'b1, 8'b1011_0101},
        {32'h0000_3000, 16'h8421, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF},
        {32'h0000_4000, 16'h00FF, 1'b0, 1'b1, 1'b0, 1'b1, 8'b0101_0101},
        {32'h0000_5000, 16'h0001, 1'b1, 1'b1, 1'b1, 1'b0, 8'hFF},
        {32'h0000_6000, 16'hFFFF, 1'b0, 1'b1, 1'b1, 1'b1, 8'b1100_1100},
        {32'hFFFF_FFF8, 16'h0006, 1'b1, 1'b0, 1'b0, 1'b1, 8'hFF},
        {32'h0000_7000, 16'h4000, 1'b1, 1'b0, 1'b1, 1'b0, 8'b0001_1111}
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic report;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // One command through its whole walk, checked against the bench model
    task automatic run_vec(input logic [59:0] v);
        logic [31:0] base = v[59:28];
        logic [15:0] mask = v[27:12];
        logic up = v[11], pre = v[10], load = v[9], wb = v[8];
        logic [7:0] pat = v[7:0];
        logic [31:0] ea;
        logic [31:0] ewb;
        int left = $countones(mask);
        int p = up ? 0 : 15;
        int cyc = 0;
        bit first = 1'b1;
        ewb = up ? base + 32'(4 * left) : base - 32'(4 * left);
        ea = pre ? (up ? base + 32'd4 : base - 32'd4) : base;
        @(negedge clk);
        cmd_base = base; cmd_mask = mask; cmd_up = up; cmd_pre = pre;
        cmd_load = load; cmd_wb = wb; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        while (left > 0 && cyc < 400) begin
            while (!mask[p]) p = up ? p + 1 : p - 1;
            req_ready = pat[cyc % 8];
            // R2 R3 R4 R5: address, index, tag and direction of this request
            check(req_valid && req_addr == ea && req_reg == 4'(p) &&
                  req_seq == !first && req_write == !load,
                  "R2/R3/R4 request", {req_valid, req_seq, req_write, req_reg, req_addr[23:0]},
                  {1'b1, !first, !load, 4'(p), ea[23:0]});
            if (req_ready) begin
                ea = up ? ea + 32'd4 : ea - 32'd4;
                first = 1'b0;
                left--;
                p = up ? p + 1 : p - 1;
            end
            cyc++;
            @(negedge clk);
        end
        req_ready = 1'b0;
        if (load) begin
            // R8: load settles one cycle before completion
            check(int_cycle && !done, "R8 load settle", {30'd0, int_cycle, done}, 32'd2);
            @(negedge clk);
        end else begin
            // R8: store has no settle cycle
            check(!int_cycle, "R8 store no settle", {31'd0, int_cycle}, 32'd0);
        end
        // R10 completion pulse timing
        check(done && !req_valid, "R10 done", {30'd0, done, req_valid}, 32'd2);
        // R6 write-back value and enable
        check(wb_addr == ewb, "R6 wb_addr", wb_addr, ewb);
        check(wb_valid == (!pre || wb), "R6 wb_valid", {31'd0, wb_valid}, {31'd0, !pre || wb});
        // R7 flush only for loads of register 15
        check(flush_req == (load && mask[15]), "R7 flush", {31'd0, flush_req},
              {31'd0, load && mask[15]});
        @(negedge clk);
        // R10 single pulse, then idle
        check(!done && !busy, "R10 after done", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            report();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state
        check(!busy && !req_valid && !done && !flush_req, "R1 reset state",
              {28'd0, busy, req_valid, done, flush_req}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !req_valid, "R1 idle after reset", {30'd0, busy, req_valid}, 32'd0);

        for (int i = 0; i < 8; i++) run_vec(VEC[i]);

        // R9: empty mask completes at once with base as write-back value
        @(negedge clk);
        cmd_base = 32'h0000_9000; cmd_mask = 16'h0000; cmd_up = 1'b1;
        cmd_pre = 1'b1; cmd_load = 1'b1; cmd_wb = 1'b1; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        check(done && !req_valid && !int_cycle, "R9 empty mask done",
              {29'd0, done, req_valid, int_cycle}, 32'd4);
        check(wb_addr == 32'h0000_9000 && wb_valid, "R9 empty mask wb", wb_addr, 32'h0000_9000);
        @(negedge clk);
        check(!busy && !done, "R9 empty mask idle", {30'd0, busy, done}, 32'd0);

        // R1 R5: start ignored during a stalled walk, request held
        cmd_base = 32'h0000_A000; cmd_mask = 16'h0003; cmd_up = 1'b1;
        cmd_pre = 1'b0; cmd_load = 1'b0; cmd_wb = 1'b0; cmd_start = 1'b1;
        @(negedge clk);
        cmd_base = 32'h0000_B000; cmd_mask = 16'h0010; cmd_up = 1'b0;
        check(busy && req_valid && req_addr == 32'h0000_A000 && req_reg == 4'd0,
              "R1 first request", req_addr, 32'h0000_A000);
        repeat (3) @(negedge clk);
        check(req_valid && req_addr == 32'h0000_A000 && req_reg == 4'd0 && !req_seq,
              "R5 stall holds request", req_addr, 32'h0000_A000);
        cmd_start = 1'b0;
        req_ready = 1'b1;
        @(negedge clk);
        check(req_valid && req_addr == 32'h0000_A004 && req_reg == 4'd1 && req_seq,
              "R1 walk unchanged by start", req_addr, 32'h0000_A004);
        @(negedge clk);
        req_ready = 1'b0;
        check(done && wb_addr == 32'h0000_A008, "R6 ignored start wb", wb_addr, 32'h0000_A008);
        @(negedge clk);

        // R4: next command starts non-sequential again
        cmd_base = 32'h0000_C000; cmd_mask = 16'h0100; cmd_up = 1'b0;
        cmd_pre = 1'b0; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        check(req_valid && !req_seq && req_reg == 4'd8, "R4 first of new command",
              {27'd0, req_seq, req_reg}, 32'd8);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        @(negedge clk);

        finished = 1'b1;
        report();
        $finish;
    end

endmodule